// File: doc/BRIEF.md
# Framebuffer Scanline Address Generator

This block produces the memory read addresses needed to fetch one frame of display pixels from a linear framebuffer. It works one scanline at a time and addresses 64-bit (8-byte) words. A small register port programs four things: the byte address of the frame's first pixel, the distance between scanlines, the number of words to fetch per line and the pixel depth. A timing generator supplies frame-start and line-start strobes. On each line start the block works out that line's base word and then issues a run of consecutive word reads. It uses a valid/ready handshake toward memory.

Software programs the pitch and the line length in 8-byte word units. The pitch is the byte pitch, rounded up to a multiple of 8 and then divided by 8. The line length is the active byte count divided by 8, plus a fixed over-fetch of two words. Each line base moves forward by the pitch and not by the number of words fetched. Geometry and depth writes are held in a pending copy and become active only at a frame start, so a frame that is already scanning never mixes two modes. A fetch-enable bit acts at once and gates all requests.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, req_valid is 0, px_depth is 0 and fetch enable is 0.
- R2: Register map selected by cfg_addr: 0 holds the start byte address, and its low 3 bits are dropped, so the start word is the byte address shifted right by 3. 1 holds the pitch in words. 2 holds the words per line. 3 is control, with bit 0 as fetch enable and bits 2:1 as the depth code.
- R3: Writes to start, pitch, line words and depth take effect only at the next frame_start. A line fetched before that uses the old values.
- R4: The first line_start after a frame_start fetches from the start word.
- R5: Each later line_start sets the line base to the previous base plus the pitch, whatever the line word count is.
- R6: An accepted line issues exactly line-words requests at consecutive word addresses from its base. A count of 0 issues none.
- R7: While req_valid is 1 and req_ready is 0, req_valid stays 1 and req_addr stays unchanged.
- R8: A line_start that arrives while fetch enable is 0 fetches nothing, but the line base still advances.
- R9: Clearing fetch enable keeps the request already presented until it is accepted. After that, no further requests are made for that line.
- R10: A line_start that arrives while the previous line is still fetching is not fetched, but it does advance the base. The line in progress completes.
- R11: Depth codes are 0 for 8 bpp, 1 for 16 bpp and 2 for 32-bit pixels. A write of code 3 leaves the pending depth unchanged. px_depth shows the active depth.
- R12: When frame_start and line_start arrive in the same cycle, that line uses the newly activated start word and line word count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | DATA_W | Register write data |
| frame_start | input | 1 | Frame start strobe from the timing generator |
| line_start | input | 1 | Line start strobe from the timing generator |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | ADDR_W-3 | Word address of the request |
| px_depth | output | 2 | Active pixel depth code |

## Verification
The bench checks the line-base arithmetic against the pitch. A design that advanced the base by the fetched length, or skipped the first-line reload, would produce drifting addresses on the second line. It writes new geometry in the middle of a frame to catch a design that applies writes at once. It applies random backpressure and clears the enable while a request is stalled, which exposes a design that drops or repeats a word, or keeps fetching. It also covers a zero-length line, a line start while the previous line is still busy, a line start while disabled, and a frame start that coincides with a line start. Each of these shows up as a wrong address count or a wrong base on the following line.

// File: rtl/fb_scan_pkg.sv
// Shared definitions for the scanline address generator.
// Assumes a 2-bit register select and 8-byte memory words.
package fb_scan_pkg;
    typedef enum logic [1:0] {
        DEPTH_8  = 2'd0,
        DEPTH_16 = 2'd1,
        DEPTH_32 = 2'd2
    } depth_e;

    localparam logic [1:0] REG_START = 2'd0;
    localparam logic [1:0] REG_PITCH = 2'd1;
    localparam logic [1:0] REG_LWORD = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    localparam int WORD_SHIFT = 3;
endpackage

// File: rtl/fb_cfg_regs.sv
// Pending and active copies of the fetch geometry.
// Writes go to the pending copy. frame_start moves pending into active.
// The eff_* outputs give the values that apply in this cycle, including
// a frame_start that arrives in the same cycle. Fetch enable acts at once.
module fb_cfg_regs
    import fb_scan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PITCH_W = 16,
    parameter int LWORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               frame_start,
    output logic [ADDR_W-4:0]  eff_start,
    output logic [PITCH_W-1:0] eff_pitch,
    output logic [LWORD_W-1:0] eff_lwords,
    output logic [1:0]         act_depth,
    output logic               fetch_en
);
    localparam int WA_W = ADDR_W - WORD_SHIFT;

    logic [WA_W-1:0]    pend_start, act_start;
    logic [PITCH_W-1:0] pend_pitch, act_pitch;
    logic [LWORD_W-1:0] pend_lw, act_lw;
    logic [1:0]         pend_depth;

    // Capture register writes into the pending copy (enable is immediate).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_start <= '0;
            pend_pitch <= '0;
            pend_lw    <= '0;
            pend_depth <= DEPTH_8;
            fetch_en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_START: pend_start <= wr_data[ADDR_W-1:WORD_SHIFT];
                REG_PITCH: pend_pitch <= wr_data[PITCH_W-1:0];
                REG_LWORD: pend_lw    <= wr_data[LWORD_W-1:0];
                default: begin
                    fetch_en <= wr_data[0];
                    if (wr_data[2:1] != 2'b11) pend_depth <= wr_data[2:1];
                end
            endcase
        end
    end

    // Promote pending values to active at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_start <= '0;
            act_pitch <= '0;
            act_lw    <= '0;
            act_depth <= DEPTH_8;
        end else if (frame_start) begin
            act_start <= pend_start;
            act_pitch <= pend_pitch;
            act_lw    <= pend_lw;
            act_depth <= pend_depth;
        end
    end

    // Values in force this cycle.
    always_comb begin
        eff_start  = frame_start ? pend_start : act_start;
        eff_pitch  = frame_start ? pend_pitch : act_pitch;
        eff_lwords = frame_start ? pend_lw    : act_lw;
    end

    // R3: active geometry never changes without a frame start
    p_frame_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (act_pitch == $past(act_pitch)) && (act_lw == $past(act_lw))
                         && (act_start == $past(act_start)) && (act_depth == $past(act_depth)));

    // R11: reserved depth code never becomes active
    p_depth_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        act_depth != 2'b11);
endmodule

// File: rtl/fb_line_base.sv
// Tracks the base word address of the current scanline.
// Reloads from the start word at frame start. The first line start of a
// frame uses that base, and each later line start adds the pitch.
// Assumes strobes are single-cycle pulses.
module fb_line_base #(
    parameter int WA_W    = 29,
    parameter int PITCH_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               line_start,
    input  logic [WA_W-1:0]    start_word,
    input  logic [PITCH_W-1:0] pitch,
    output logic [WA_W-1:0]    go_addr
);
    logic [WA_W-1:0] base;
    logic            first;

    // Base for a line that starts this cycle.
    always_comb begin
        if (frame_start)  go_addr = start_word;
        else if (first)   go_addr = base;
        else              go_addr = base + WA_W'(pitch);
    end

    // Hold the base and the first-line flag between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base  <= '0;
            first <= 1'b1;
        end else if (line_start) begin
            base  <= go_addr;
            first <= 1'b0;
        end else if (frame_start) begin
            base  <= start_word;
            first <= 1'b1;
        end
    end

    // R5: base moves only on a strobe
    p_base_still_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !frame_start) |=> (base == $past(base)));

    // R4: after a lone frame start the next line begins at the start word
    p_first_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !line_start) |=> (first && base == $past(start_word)));
endmodule

// File: rtl/fb_word_fetch.sv
// Issues the word read requests for one scanline over a valid/ready port.
// A line is taken only when idle and enabled with a non-zero count.
// Clearing enable ends the line after the presented request is accepted.
module fb_word_fetch #(
    parameter int WA_W    = 29,
    parameter int LWORD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_go,
    input  logic [WA_W-1:0]    go_addr,
    input  logic [LWORD_W-1:0] go_words,
    input  logic               fetch_en,
    input  logic               req_ready,
    output logic               req_valid,
    output logic [WA_W-1:0]    req_addr
);
    logic [LWORD_W-1:0] remain;
    logic               busy;

    // Line request state machine: load, step on accept, stop at count or disable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            req_addr <= '0;
            remain   <= '0;
        end else if (busy) begin
            if (req_ready) begin
                req_addr <= req_addr + 1'b1;
                remain   <= remain - 1'b1;
                if (remain == LWORD_W'(1) || !fetch_en) busy <= 1'b0;
            end
        end else if (line_go && fetch_en && go_words != '0) begin
            busy     <= 1'b1;
            req_addr <= go_addr;
            remain   <= go_words;
        end
    end

    assign req_valid = busy;

    // R7: a stalled request is held unchanged
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && req_addr == $past(req_addr)));

    // R6: consecutive requests within a line step by one word
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && remain != LWORD_W'(1) && fetch_en)
            |=> (req_valid && req_addr == $past(req_addr) + 1'b1));

    // R6: a busy line always has words left
    p_count_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != '0));

    // R9: nothing new is issued while disabled
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_en && !req_valid) |=> !req_valid);
endmodule

// File: rtl/fb_scan_addr_gen.sv
// Framebuffer scanline address generator top level.
// Connects the register shadows, the line base tracker and the word fetcher.
// Assumes ADDR_W <= DATA_W and strobes from a single timing source.
module fb_scan_addr_gen
    import fb_scan_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PITCH_W = 16,
    parameter int LWORD_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr,
    input  logic [1:0]                    cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    input  logic                          frame_start,
    input  logic                          line_start,
    output logic                          req_valid,
    input  logic                          req_ready,
    output logic [ADDR_W-WORD_SHIFT-1:0]  req_addr,
    output logic [1:0]                    px_depth
);
    localparam int WA_W = ADDR_W - WORD_SHIFT;

    logic [WA_W-1:0]    eff_start, go_addr;
    logic [PITCH_W-1:0] eff_pitch;
    logic [LWORD_W-1:0] eff_lwords;
    logic               fetch_en;

    fb_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PITCH_W(PITCH_W), .LWORD_W(LWORD_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
        .wr_data(cfg_wdata), .frame_start(frame_start),
        .eff_start(eff_start), .eff_pitch(eff_pitch), .eff_lwords(eff_lwords),
        .act_depth(px_depth), .fetch_en(fetch_en)
    );

    fb_line_base #(.WA_W(WA_W), .PITCH_W(PITCH_W)) u_base (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .line_start(line_start), .start_word(eff_start), .pitch(eff_pitch),
        .go_addr(go_addr)
    );

    fb_word_fetch #(.WA_W(WA_W), .LWORD_W(LWORD_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .line_go(line_start), .go_addr(go_addr),
        .go_words(eff_lwords), .fetch_en(fetch_en), .req_ready(req_ready),
        .req_valid(req_valid), .req_addr(req_addr)
    );

    // R6: an idle, enabled line start with words loads the fetcher at the line base
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !req_valid && fetch_en && eff_lwords != '0)
            |=> (req_valid && req_addr == $past(go_addr)));

    // R8: a disabled line start issues nothing
    p_off_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !req_valid && !fetch_en) |=> !req_valid);
endmodule

// File: tb/fb_scan_addr_gen_test.sv
module fb_scan_addr_gen_test;
    localparam int WA_W = 29;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [1:0]       cfg_addr = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             frame_start = 1'b0;
    logic             line_start = 1'b0;
    logic             req_valid;
    logic             req_ready;
    logic [WA_W-1:0]  req_addr;
    logic [1:0]       px_depth;

    logic             rnd_mode = 1'b0;
    logic             force_rdy = 1'b1;
    logic [15:0]      lfsr = 16'hACE1;
    int               n_run = 0;
    int               n_fail = 0;
    int               log_n = 0;
    logic [WA_W-1:0]  log_a [0:255];

    always #5 clk = ~clk;

    fb_scan_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .line_start(line_start),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .px_depth(px_depth)
    );

    assign req_ready = rnd_mode ? lfsr[0] : force_rdy;

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    // record every accepted request
    always @(posedge clk) begin
        if (req_valid && req_ready && log_n < 256) begin
            log_a[log_n] = req_addr;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_line();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 500 && req_valid; i++) @(negedge clk);
    endtask

    // start a line, wait until done, compare the accepted addresses
    task automatic do_line(input logic [WA_W-1:0] base, input int n, input string req);
        int s;
        s = log_n;
        pulse_line();
        wait_idle();
        check(log_n - s == n, {req, " count"}, log_n - s, n);
        for (int j = 0; j < n && s + j < log_n; j++)
            check(log_a[s+j] == base + j, {req, " addr"}, log_a[s+j], base + j);
    endtask

    task automatic t_reset();
        check(req_valid == 1'b0, "R1 valid", req_valid, 0);
        check(px_depth == 2'd0, "R1 depth", px_depth, 0);
        pulse_line(); // enable is 0 after reset: nothing issued
        check(req_valid == 1'b0, "R1 enable off", req_valid, 0);
    endtask

    task automatic t_basic();
        // R2: start byte 0x2005 -> word 0x400
        wr(2'd0, 32'h2005); wr(2'd1, 12); wr(2'd2, 7); wr(2'd3, 32'h1);
        pulse_frame();
        rnd_mode = 1'b1;
        do_line(29'h400, 7, "R4 first line");
        do_line(29'h40C, 7, "R5 second line");
        do_line(29'h418, 7, "R6 third line");
        rnd_mode = 1'b0;
    endtask

    task automatic t_shadow();
        // R3: geometry writes mid-frame wait for the next frame start
        wr(2'd1, 20); wr(2'd2, 4); wr(2'd0, 32'h3000);
        do_line(29'h424, 7, "R3 old geometry");
        pulse_frame();
        do_line(29'h600, 4, "R3 new start");
        do_line(29'h614, 4, "R3 new pitch");
    endtask

    task automatic t_zero();
        wr(2'd2, 0); pulse_frame();
        do_line(29'h600, 0, "R6 zero words");
        wr(2'd2, 4); pulse_frame();
    endtask

    task automatic t_disabled_line();
        do_line(29'h600, 4, "R8 before");
        wr(2'd3, 32'h0);
        pulse_line();
        @(negedge clk);
        check(req_valid == 1'b0, "R8 no fetch", req_valid, 0);
        wr(2'd3, 32'h1);
        do_line(29'h628, 4, "R8 base advanced");
    endtask

    task automatic t_disable_mid();
        int s;
        wr(2'd2, 5); pulse_frame();
        s = log_n;
        force_rdy = 1'b0;
        pulse_line();
        force_rdy = 1'b1;
        @(negedge clk); @(negedge clk);
        force_rdy = 1'b0;
        cfg_wr = 1'b1; cfg_addr = 2'd3; cfg_wdata = 32'h0;
        @(negedge clk); cfg_wr = 1'b0;
        @(negedge clk); @(negedge clk);
        check(req_valid == 1'b1, "R9 held valid", req_valid, 1);
        check(req_addr == 29'h602, "R9 held addr", req_addr, 29'h602);
        force_rdy = 1'b1;
        @(negedge clk);
        check(req_valid == 1'b0, "R9 stop", req_valid, 0);
        repeat (3) @(negedge clk);
        check(log_n - s == 3, "R9 count", log_n - s, 3);
        wr(2'd3, 32'h1);
    endtask

    task automatic t_busy_line();
        int s;
        wr(2'd2, 3); pulse_frame();
        s = log_n;
        force_rdy = 1'b0;
        pulse_line();
        pulse_line();          // arrives while busy
        force_rdy = 1'b1;
        wait_idle();
        check(log_n - s == 3, "R10 count", log_n - s, 3);
        check(log_a[s+2] == 29'h602, "R10 last", log_a[s+2], 29'h602);
        do_line(29'h628, 3, "R10 base");
    endtask

    task automatic t_depth();
        wr(2'd3, 32'h5);       // enable, depth 2
        check(px_depth == 2'd0, "R11 not yet", px_depth, 0);
        pulse_frame();
        check(px_depth == 2'd2, "R11 32-bit", px_depth, 2);
        wr(2'd3, 32'h7);       // code 3 ignored
        pulse_frame();
        check(px_depth == 2'd2, "R11 code 3", px_depth, 2);
        wr(2'd3, 32'h3); pulse_frame();
        check(px_depth == 2'd1, "R11 16 bpp", px_depth, 1);
    endtask

    task automatic t_same_cycle();
        int s;
        wr(2'd0, 32'h800); wr(2'd2, 2);
        s = log_n;
        @(negedge clk); frame_start = 1'b1; line_start = 1'b1;
        @(negedge clk); frame_start = 1'b0; line_start = 1'b0;
        wait_idle();
        check(log_n - s == 2, "R12 count", log_n - s, 2);
        check(log_a[s] == 29'h100, "R12 addr", log_a[s], 29'h100);
        do_line(29'h114, 2, "R12 next");
    endtask

    initial begin
        #1000000;
        check(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_shadow();
        t_zero();
        t_disabled_line();
        t_disable_mid();
        t_busy_line();
        t_depth();
        t_same_cycle();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule